// File: doc/BRIEF.md
# Pin-Muxed Parallel I/O Port

This block runs a nine-pin port that is mapped onto a small register bus. Software can hand each pin to one of two on-chip serial engines, or keep it as a general-purpose pin. A general-purpose pin is driven or sampled under software control. A pin that is handed over is driven entirely by its serial engine. Pins 0 to 2 belong to the asynchronous serial engine. Pins 3 to 8 belong to the synchronous serial engine.

Three registers control the port, and each holds nine meaningful bits:

- **Function select at 0xFFE1:** a 1 hands the pin to its serial engine.
- **Direction at 0xFFE3:** a 1 makes the pin an output.
- **Data at 0xFFE5:** a write sets the output levels. A read returns a mix of the latched output bits and the synchronized input levels, chosen pin by pin by the direction bit.

Every pin input passes through a two-flop synchronizer. The synchronized levels feed both the data register read path and the serial engines. The block has an asynchronous active-low reset, which is released synchronously to the clock.

Top module: `pin_mux_port`

## Requirements
- R1: Two clock edges after reset is released, the select, direction and data registers all read zero and every `pin_oe` bit is low, so each pin starts as a general-purpose input.
- R2: A write with `bus_we` high at address 0xFFE1 stores `bus_wdata[8:0]` into the select register on that clock edge. A read of 0xFFE1 returns the stored value with bits 23..9 at zero.
- R3: A write at 0xFFE3 stores `bus_wdata[8:0]` into the direction register, and reads return zero above bit 8. For a general-purpose pin, `pin_oe[i]` equals direction bit i, where 1 means output.
- R4: A write at 0xFFE5 stores `bus_wdata[8:0]` into the data register. For a general-purpose pin, `pin_out[i]` equals data bit i.
- R5: A read of 0xFFE5 returns, for each bit i, the data register bit if direction bit i is 1. Otherwise it returns the level of `pin_in[i]` as sampled two rising edges earlier: a change applied before edge k is visible after edge k+1 and not after edge k. Bits 23..9 read zero.
- R6: When select bit i is 1, `pin_out[i]` and `pin_oe[i]` follow the serial engine's drive and enable for that pin. The direction and data bits for that pin have no effect on them.
- R7: Serial routing is fixed. Pin i for i in 0..2 pairs with bit i of the `aser_*` signals. Pin 3+k for k in 0..5 pairs with bit k of the `sser_*` signals.
- R8: A serial engine input bit carries the synchronized level of its pin when that pin's select bit is 1. It is 0 when the pin is general-purpose.
- R9: Reads of any address other than 0xFFE1, 0xFFE3 and 0xFFE5 return zero. Writes to such addresses leave all three registers unchanged.
- R10: With `bus_we` low, no register changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for `bus_addr`, combinational |
| pin_in | input | 9 | Pin levels seen at the pads |
| pin_out | output | 9 | Pin drive values |
| pin_oe | output | 9 | Pin output enables, 1 = drive |
| aser_out | input | 3 | Asynchronous serial engine drive for pins 0..2 |
| aser_oe | input | 3 | Asynchronous serial engine enables for pins 0..2 |
| aser_in | output | 3 | Synchronized pins 0..2 toward the asynchronous engine |
| sser_out | input | 6 | Synchronous serial engine drive for pins 3..8 |
| sser_oe | input | 6 | Synchronous serial engine enables for pins 3..8 |
| sser_in | output | 6 | Synchronized pins 3..8 toward the synchronous engine |

## Verification
The assertions check on every cycle that the registers change only on a decoded, enabled write and then hold exactly the written low bits. They also check that the synchronizer output always trails the pads by two edges. The per-pin choice between software and serial-engine control can only be shown by the bench's scenarios. The same holds for the gating of engine inputs, the mixed read-back of the data register and the fixed pin-to-engine routing, which the bench exercises with mixed select, direction and pin patterns.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  // Register targets of the bus decoder
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_SEL  = 2'd1,
    REG_DIR  = 2'd2,
    REG_DAT  = 2'd3
  } pmp_reg_e;

endpackage

// File: rtl/pmp_rst_sync.sv
module pmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] rs_d;

  always_comb begin
    rs_d = {rs_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rs_q <= '0;
    else          rs_q <= rs_d;
  end

  assign rst_n_o = rs_q[STAGES-1];

endmodule

// File: rtl/pmp_sync.sv
module pmp_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stg_d[s] = din;
    end else begin : g_next
      always_comb stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign dout = stg_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] age_q;
    logic [1:0] age_d;

    always_comb age_d = (age_q == 2'd2) ? age_q : age_q + 2'd1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age_q <= '0;
      else        age_q <= age_d;
    end

    // R5
    sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2) |-> (dout == $past(din, 2)));
  end

endmodule

// File: rtl/pmp_regs.sv
module pmp_regs
  import pmp_pkg::*;
#(
  parameter int unsigned W        = 9,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 24,
  parameter logic [15:0] SEL_ADDR = 16'hFFE1,
  parameter logic [15:0] DIR_ADDR = 16'hFFE3,
  parameter logic [15:0] DAT_ADDR = 16'hFFE5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      sel_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      dat_q
);

  pmp_reg_e     hit;
  logic         sel_en, dir_en, dat_en;
  logic [W-1:0] wr_val;
  logic [W-1:0] sel_d, dir_d, dat_d;
  logic [W-1:0] dat_rd;
  logic [W-1:0] rd_vec;
  logic         unused_wdata_hi;

  // Address decode
  always_comb begin
    hit = REG_NONE;
    if      (bus_addr == ADDR_W'(SEL_ADDR)) hit = REG_SEL;
    else if (bus_addr == ADDR_W'(DIR_ADDR)) hit = REG_DIR;
    else if (bus_addr == ADDR_W'(DAT_ADDR)) hit = REG_DAT;
  end

  // Next state and clock enables
  always_comb begin
    wr_val = bus_wdata[W-1:0];
    sel_en = bus_we && (hit == REG_SEL);
    dir_en = bus_we && (hit == REG_DIR);
    dat_en = bus_we && (hit == REG_DAT);
    sel_d  = wr_val;
    dir_d  = wr_val;
    dat_d  = wr_val;
  end

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= dat_d;
  end

  // Read path: outputs return latched value, inputs return pad level
  for (genvar i = 0; i < W; i++) begin : g_rd
    assign dat_rd[i] = dir_q[i] ? dat_q[i] : pin_sync[i];
  end

  always_comb begin
    unique case (hit)
      REG_SEL: rd_vec = sel_q;
      REG_DIR: rd_vec = dir_q;
      REG_DAT: rd_vec = dat_rd;
      default: rd_vec = '0;
    endcase
  end

  assign bus_rdata = DATA_W'(rd_vec);

  // R2
  sel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(SEL_ADDR)) |=> (sel_q == $past(bus_wdata[W-1:0])));

  // R3
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(DIR_ADDR)) |=> (dir_q == $past(bus_wdata[W-1:0])));

  // R4
  dat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(DAT_ADDR)) |=> (dat_q == $past(bus_wdata[W-1:0])));

  // R10
  no_we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(sel_q) && $stable(dir_q) && $stable(dat_q)));

  // R9
  unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(SEL_ADDR) && bus_addr != ADDR_W'(DIR_ADDR) &&
     bus_addr != ADDR_W'(DAT_ADDR))
    |=> ($stable(sel_q) && $stable(dir_q) && $stable(dat_q)));

endmodule

// File: rtl/pmp_pinmux.sv
module pmp_pinmux #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] sel,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] dat,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] per_out,
  input  logic [W-1:0] per_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] per_in
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (sel[i]) begin
        pin_out[i] = per_out[i];
        pin_oe[i]  = per_oe[i];
        per_in[i]  = pin_sync[i];
      end else begin
        pin_out[i] = dat[i];
        pin_oe[i]  = dir[i];
        per_in[i]  = 1'b0;
      end
    end
  end

endmodule

// File: rtl/pin_mux_port.sv
module pin_mux_port #(
  parameter int unsigned ASER_PINS = 3,
  parameter int unsigned SSER_PINS = 6,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned SYNC_STG  = 2,
  parameter logic [15:0] SEL_ADDR  = 16'hFFE1,
  parameter logic [15:0] DIR_ADDR  = 16'hFFE3,
  parameter logic [15:0] DAT_ADDR  = 16'hFFE5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [ASER_PINS+SSER_PINS-1:0] pin_in,
  output logic [ASER_PINS+SSER_PINS-1:0] pin_out,
  output logic [ASER_PINS+SSER_PINS-1:0] pin_oe,
  input  logic [ASER_PINS-1:0]          aser_out,
  input  logic [ASER_PINS-1:0]          aser_oe,
  output logic [ASER_PINS-1:0]          aser_in,
  input  logic [SSER_PINS-1:0]          sser_out,
  input  logic [SSER_PINS-1:0]          sser_oe,
  output logic [SSER_PINS-1:0]          sser_in
);

  localparam int unsigned NPINS = ASER_PINS + SSER_PINS;

  logic             rst_n_int;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] sel_q, dir_q, dat_q;
  logic [NPINS-1:0] per_out, per_oe, per_in;

  pmp_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  pmp_sync #(.W(NPINS), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (pin_in),
    .dout  (pin_sync)
  );

  pmp_regs #(
    .W(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SEL_ADDR(SEL_ADDR), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .sel_q     (sel_q),
    .dir_q     (dir_q),
    .dat_q     (dat_q)
  );

  // Fixed routing: low pins to the asynchronous engine, upper to the synchronous one
  assign per_out = {sser_out, aser_out};
  assign per_oe  = {sser_oe, aser_oe};
  assign aser_in = per_in[ASER_PINS-1:0];
  assign sser_in = per_in[NPINS-1:ASER_PINS];

  pmp_pinmux #(.W(NPINS)) u_mux (
    .sel      (sel_q),
    .dir      (dir_q),
    .dat      (dat_q),
    .pin_sync (pin_sync),
    .per_out  (per_out),
    .per_oe   (per_oe),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .per_in   (per_in)
  );

endmodule

// File: tb/test_pin_mux_port.sv
module test_pin_mux_port;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_we;
  logic [23:0] bus_wdata;
  logic [23:0] bus_rdata;
  logic [8:0]  pin_in, pin_out, pin_oe;
  logic [2:0]  aser_out, aser_oe, aser_in;
  logic [5:0]  sser_out, sser_oe, sser_in;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pin_mux_port i_pin_mux_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .aser_out(aser_out), .aser_oe(aser_oe),
    .aser_in(aser_in), .sser_out(sser_out), .sser_oe(sser_oe), .sser_in(sser_in)
  );

  // {address, write data, expected read-back}
  localparam logic [63:0] VEC [7] = '{
    {16'hFFE1, 24'hFFFFFF, 24'h0001FF},
    {16'hFFE1, 24'h123456, 24'h000056},
    {16'hFFE3, 24'hABCDEF, 24'h0001EF},
    {16'hFFE3, 24'h000000, 24'h000000},
    {16'hFFE0, 24'hFFFFFF, 24'h000000},
    {16'hFFE2, 24'hFFFFFF, 24'h000000},
    {16'hFFE6, 24'hFFFFFF, 24'h000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [23:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [23:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(4 * 20000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [23:0] r;
    logic [8:0]  sel, dir, dat, pins, exp_out, exp_oe;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    pin_in = '0; aser_out = '0; aser_oe = '0; sser_out = '0; sser_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 oe", 32'(pin_oe), 0);
    rd(16'hFFE1, r); chk("R1 sel", 32'(r), 0);
    rd(16'hFFE3, r); chk("R1 dir", 32'(r), 0);
    rd(16'hFFE5, r); chk("R1 dat", 32'(r), 0);

    // Table walk: write then read back
    for (int v = 0; v < 7; v++) begin
      wr(VEC[v][63:48], VEC[v][47:24]);
      rd(VEC[v][63:48], r);
      if (VEC[v][63:48] == 16'hFFE1)      chk("R2 sel readback", 32'(r), 32'(VEC[v][23:0]));
      else if (VEC[v][63:48] == 16'hFFE3) chk("R3 dir readback", 32'(r), 32'(VEC[v][23:0]));
      else                                chk("R9 unmapped read", 32'(r), 32'(VEC[v][23:0]));
    end
    rd(16'hFFE1, r); chk("R9 sel unchanged", 32'(r), 32'h056);
    rd(16'hFFE3, r); chk("R9 dir unchanged", 32'(r), 0);

    // R10 write data without strobe
    @(negedge clk); bus_addr = 16'hFFE1; bus_wdata = 24'h0001AA; bus_we = 1'b0;
    @(negedge clk);
    rd(16'hFFE1, r); chk("R10 sel held", 32'(r), 32'h056);

    // R3 R4 general-purpose drive
    wr(16'hFFE1, 24'h0);
    wr(16'hFFE5, 24'h000155);
    wr(16'hFFE3, 24'h0000F0);
    chk("R3 oe", 32'(pin_oe), 32'h0F0);
    chk("R4 out", 32'(pin_out), 32'h155);

    // R5 mixed read-back
    pin_in = 9'h0AA;
    repeat (3) @(negedge clk);
    rd(16'hFFE5, r);
    chk("R5 mixed read", 32'(r), 32'((9'h155 & 9'h0F0) | (9'h0AA & ~9'h0F0)));

    // R5 two-edge latency
    wr(16'hFFE3, 24'h0);
    pin_in = 9'h000;
    repeat (3) @(negedge clk);
    pin_in = 9'h1FF;
    @(negedge clk);
    rd(16'hFFE5, r); chk("R5 after one edge", 32'(r), 0);
    @(negedge clk);
    rd(16'hFFE5, r); chk("R5 after two edges", 32'(r), 32'h1FF);

    // R6 R7 all pins serial, direction and data ignored
    aser_out = 3'b101; aser_oe = 3'b011; sser_out = 6'b110010; sser_oe = 6'b101101;
    wr(16'hFFE1, 24'h1FF);
    chk("R7 out routing", 32'(pin_out), 32'({6'b110010, 3'b101}));
    chk("R7 oe routing", 32'(pin_oe), 32'({6'b101101, 3'b011}));
    wr(16'hFFE3, 24'h1FF);
    wr(16'hFFE5, 24'h0AA);
    chk("R6 out ignores gpio", 32'(pin_out), 32'({6'b110010, 3'b101}));
    chk("R6 oe ignores gpio", 32'(pin_oe), 32'({6'b101101, 3'b011}));

    // R6 partial select
    sel = 9'h00F; dir = 9'h1FF; dat = 9'h0AA;
    wr(16'hFFE1, 24'(sel));
    exp_out = (sel & {6'b110010, 3'b101}) | (~sel & dat);
    exp_oe  = (sel & {6'b101101, 3'b011}) | (~sel & dir);
    chk("R6 partial out", 32'(pin_out), 32'(exp_out));
    chk("R6 partial oe", 32'(pin_oe), 32'(exp_oe));

    // R8 engine inputs gated by select
    pins = 9'h1AB;
    pin_in = pins;
    wr(16'hFFE1, 24'h1F8);
    repeat (2) @(negedge clk);
    chk("R8 aser gated", 32'(aser_in), 0);
    chk("R8 sser passes", 32'(sser_in), 32'(pins[8:3]));
    wr(16'hFFE1, 24'h007);
    chk("R8 aser passes", 32'(aser_in), 32'(pins[2:0]));
    chk("R8 sser gated", 32'(sser_in), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule